// File: doc/BRIEF.md
# Video Register Command Decoder

This block sits behind a byte-wide command stream that programs a display controller. It scans the stream for a start byte followed by an opcode. It executes register-write commands into a bank of 8-bit video timing and control registers. It also recognises a short copy command and hands its fields downstream on a one-cycle strobe. Any byte that arrives outside a command frame is dropped, so a damaged stream falls back into step at the next start byte.

Register writes always land in a shadow bank. A write to the reserved address 0xFF locks or unlocks the bank. While the bank is unlocked, every write also reaches the active bank at once. While it is locked, the active bank is held. The unlock write copies the whole shadow bank into the active bank in a single cycle, so a set of timing values takes effect together. The active bank feeds a few decoded timing fields and a read port.

The bank holds `NREGS` registers. Addresses at or above `NREGS` other than 0xFF are ignored. `NREGS` must be larger than 0x28 so that the fixed field addresses exist.

Top module: `vidcmd_decoder`

## Requirements
- R1: A command starts with byte 0xAF followed by an opcode byte. Every byte received while no command is open, other than 0xAF, is discarded with no effect.
- R2: Opcode 0x20 takes one address byte and then one data byte. When the bank is unlocked, the written value appears on `rd_data` for that address in the cycle after the data byte is accepted.
- R3: Writing 0x00 to address 0xFF sets `locked`. While `locked` is high, writes change only the shadow bank, and every active-bank output stays unchanged.
- R4: Writing 0xFF to address 0xFF clears `locked`. In the same cycle it loads every active register from the shadow bank.
- R5: `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}, with the most significant byte at the lowest address.
- R6: `h_pixels` is {reg 0x0F, reg 0x10}, with the high byte at the lower address. `pix_clk` is {reg 0x1C, reg 0x1B}, with the low byte at the lower address.
- R7: `depth16` is high exactly when active register 0x00 holds 0.
- R8: Opcode 0x6A takes 7 payload bytes, in the order source (3 bytes, MSB first), count (1 byte), destination (3 bytes, MSB first). A payload byte equal to 0xAF is treated as data. `copy_stb` is high for exactly the one cycle after the last payload byte is accepted, and the fields are valid during that cycle.
- R9: Any opcode other than 0x20, 0x6A or 0xAF sets `err`. `err` stays set until reset, and the parser goes back to looking for 0xAF.
- R10: A 0xAF received in the opcode position starts the command again. A lone trailing 0xAF causes no register change, no strobe and no error.
- R11: A cycle with `in_valid` low leaves the parser and all outputs unchanged. `in_ready` is always high.
- R12: A write to address 0xFF with a data value other than 0x00 or 0xFF, or a write to an address at or above `NREGS`, changes no register and no lock state.
- R13: After reset the bank is unlocked, all registers are zero, `err` is low and `copy_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always 1 |
| rd_addr | input | 8 | Active-bank read address |
| rd_data | output | 8 | Active register at rd_addr, 0 when out of range |
| locked | output | 1 | Bank lock state |
| err | output | 1 | Sticky unknown-opcode flag |
| depth16 | output | 1 | Colour depth select is 16 bpp |
| base16 | output | 24 | 16 bpp framebuffer base |
| base8 | output | 24 | 8 bpp framebuffer base |
| h_pixels | output | 16 | Horizontal active pixels |
| pix_clk | output | 16 | Pixel clock field |
| copy_stb | output | 1 | Copy command completed |
| copy_src | output | 24 | Copy source address |
| copy_cnt | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |

## Verification
Two events can fall in the same cycle. The copy strobe appears while the parser is already taking the start byte of the next command. The unlock commit updates the lock flag and the whole active bank at one edge. The stream provokes both cases: a copy is followed at once by a register write, and several staged writes are released by one unlock. A behavioural model of the stream rules, updated at each accepted byte, predicts every output. It is compared on every clock, so a strobe that is late or lost, or a commit that is partial or a cycle late, shows as a mismatch in that exact cycle.

// File: rtl/vidcmd_decoder.sv
module vidcmd_decoder #(
  parameter int NREGS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        locked,
  output logic        err,
  output logic        depth16,
  output logic [23:0] base16,
  output logic [23:0] base8,
  output logic [15:0] h_pixels,
  output logic [15:0] pix_clk,
  output logic        copy_stb,
  output logic [23:0] copy_src,
  output logic [7:0]  copy_cnt,
  output logic [23:0] copy_dst
);
  localparam int IW = $clog2(NREGS);
  localparam logic [7:0] START = 8'hAF;
  localparam logic [7:0] OP_WR = 8'h20;
  localparam logic [7:0] OP_CP = 8'h6A;
  localparam logic [7:0] CTRL  = 8'hFF;
  localparam int CP_LEN = 7;
  localparam int A_DEPTH = 0;
  localparam int A_HPIX  = 15;
  localparam int A_PCLK  = 27;
  localparam int A_B16   = 32;
  localparam int A_B8    = 38;

  typedef enum logic [2:0] {S_HUNT, S_OP, S_ADDR, S_DATA, S_COPY} st_t;

  st_t        st;
  logic [7:0] wa;
  logic [2:0] cnt;
  logic [7:0] pay [0:CP_LEN-2];
  logic [7:0] shd [0:NREGS-1];
  logic [7:0] act [0:NREGS-1];

  wire          in_data_st = st == S_DATA && in_valid;
  wire          ctl_wr     = in_data_st && wa == CTRL;
  wire          do_lock    = ctl_wr && in_data == 8'h00;
  wire          do_unlock  = ctl_wr && in_data == 8'hFF;
  wire          reg_wr     = in_data_st && int'(wa) < NREGS;
  wire [IW-1:0] wi         = wa[IW-1:0];

  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        shd[i] <= '0;
        act[i] <= '0;
      end
    end else begin
      if (reg_wr) begin
        shd[wi] <= in_data;
        if (!locked) act[wi] <= in_data;
      end
      if (do_unlock)
        for (int i = 0; i < NREGS; i++) act[i] <= shd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HUNT;
      wa       <= '0;
      cnt      <= '0;
      locked   <= 1'b0;
      err      <= 1'b0;
      copy_stb <= 1'b0;
      copy_src <= '0;
      copy_cnt <= '0;
      copy_dst <= '0;
      for (int i = 0; i < CP_LEN-1; i++) pay[i] <= '0;
    end else begin
      copy_stb <= 1'b0;
      if (in_valid) begin
        case (st)
          S_HUNT: if (in_data == START) st <= S_OP;
          S_OP: begin
            case (in_data)
              START:   st <= S_OP;
              OP_WR:   st <= S_ADDR;
              OP_CP: begin
                st  <= S_COPY;
                cnt <= '0;
              end
              default: begin
                err <= 1'b1;
                st  <= S_HUNT;
              end
            endcase
          end
          S_ADDR: begin
            wa <= in_data;
            st <= S_DATA;
          end
          S_DATA: begin
            st <= S_HUNT;
            if (do_lock)   locked <= 1'b1;
            if (do_unlock) locked <= 1'b0;
          end
          S_COPY: begin
            if (int'(cnt) == CP_LEN-1) begin
              st       <= S_HUNT;
              copy_stb <= 1'b1;
              copy_src <= {pay[0], pay[1], pay[2]};
              copy_cnt <= pay[3];
              copy_dst <= {pay[4], pay[5], in_data};
            end else begin
              pay[cnt] <= in_data;
              cnt      <= cnt + 3'd1;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  assign rd_data  = (int'(rd_addr) < NREGS) ? act[rd_addr[IW-1:0]] : 8'h00;
  assign depth16  = act[IW'(A_DEPTH)] == 8'h00;
  assign base16   = {act[IW'(A_B16)], act[IW'(A_B16+1)], act[IW'(A_B16+2)]};
  assign base8    = {act[IW'(A_B8)], act[IW'(A_B8+1)], act[IW'(A_B8+2)]};
  assign h_pixels = {act[IW'(A_HPIX)], act[IW'(A_HPIX+1)]};
  assign pix_clk  = {act[IW'(A_PCLK+1)], act[IW'(A_PCLK)]};
endmodule

// File: rtl/vidcmd_decoder_chk.sv
module vidcmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        locked,
  input logic        err,
  input logic        copy_stb,
  input logic [15:0] pix_clk,
  input logic [23:0] base16
);
  assert_copy_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    copy_stb |=> !copy_stb);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_lock_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && in_data == 8'h00));

  assert_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(in_valid && in_data == 8'hFF));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> ($stable(pix_clk) && $stable(base16)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(locked) && $stable(err) && !copy_stb));
endmodule

bind vidcmd_decoder vidcmd_decoder_chk u_chk (.*);

// File: tb/tb_vidcmd_decoder.sv
module tb_vidcmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 48;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_data = 0, rd_addr = 0;
  logic in_ready, locked, err, depth16, copy_stb;
  logic [7:0] rd_data, copy_cnt;
  logic [23:0] base16, base8, copy_src, copy_dst;
  logic [15:0] h_pixels, pix_clk;

  vidcmd_decoder #(.NREGS(NR)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int ms, maddr, mcnt;
  int mp[7];
  int act[256], shd[256];
  bit mlock, merr, mstb;
  int msrc, mcf, mdst;

  function automatic int rg(int a);
    return act[a];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mlock = 0; merr = 0; mstb = 0; mcnt = 0; maddr = 0;
      for (int i = 0; i < 256; i++) begin act[i] = 0; shd[i] = 0; end
    end else begin
      mstb = 0;
      if (in_valid) begin
        int b;
        b = in_data;
        if (ms == 0) begin
          if (b == 'hAF) ms = 1;
        end else if (ms == 1) begin
          if (b == 'hAF) ms = 1;
          else if (b == 'h20) ms = 2;
          else if (b == 'h6A) begin ms = 4; mcnt = 0; end
          else begin merr = 1; ms = 0; end
        end else if (ms == 2) begin
          maddr = b; ms = 3;
        end else if (ms == 3) begin
          ms = 0;
          if (maddr == 'hFF) begin
            if (b == 0) mlock = 1;
            else if (b == 'hFF) begin
              mlock = 0;
              for (int i = 0; i < NR; i++) act[i] = shd[i];
            end
          end else if (maddr < NR) begin
            shd[maddr] = b;
            if (!mlock) act[maddr] = b;
          end
        end else begin
          mp[mcnt] = b; mcnt++;
          if (mcnt == 7) begin
            ms = 0; mstb = 1;
            msrc = (mp[0] << 16) | (mp[1] << 8) | mp[2];
            mcf = mp[3];
            mdst = (mp[4] << 16) | (mp[5] << 8) | mp[6];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 ready", in_ready, 1);
      chk("R3 locked", locked, mlock);
      chk("R9 err", err, merr);
      chk("R8 stb", copy_stb, mstb);
      if (mstb) begin
        chk("R8 src", copy_src, msrc);
        chk("R8 cnt", copy_cnt, mcf);
        chk("R8 dst", copy_dst, mdst);
      end
      chk("R2 rd_data", rd_data, rd_addr < NR ? rg(rd_addr) : 0);
      chk("R7 depth16", depth16, rg(0) == 0);
      chk("R5 base16", base16, (rg('h20) << 16) | (rg('h21) << 8) | rg('h22));
      chk("R5 base8", base8, (rg('h26) << 16) | (rg('h27) << 8) | rg('h28));
      chk("R6 h_pixels", h_pixels, (rg('h0F) << 8) | rg('h10));
      chk("R6 pix_clk", pix_clk, (rg('h1C) << 8) | rg('h1B));
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); #1;
    in_valid = 1; in_data = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 0; in_data = 8'h00;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send(8'hAF); send(8'h20); send(a); send(d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(1);
    chk("R13 locked", locked, 0);
    chk("R13 err", err, 0);
    chk("R13 stb", copy_stb, 0);
    chk("R13 pix_clk", pix_clk, 0);

    // resync: stray bytes before a command are discarded
    send(8'h11); send(8'h20); send(8'hFF); send(8'h00);
    wr(8'h00, 8'h01); idle(1);
    chk("R1 resync write", rd_data, 8'h01);
    chk("R7 depth16 low", depth16, 0);

    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF); idle(1);
    chk("R5 base16", base16, 24'h123456);
    chk("R5 base8", base8, 24'hABCDEF);

    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    wr(8'h0F, 8'h05); wr(8'h10, 8'h00); idle(1);
    chk("R6 pix_clk little end", pix_clk, 16'h1234);
    chk("R6 h_pixels big end", h_pixels, 16'h0500);

    // lock, stage, stall mid-command, then commit
    wr(8'hFF, 8'h00); idle(1);
    chk("R3 locked set", locked, 1);
    rd_addr = 8'h20;
    wr(8'h20, 8'h99);
    send(8'hAF); idle(3); send(8'h20); idle(2); send(8'h1B); idle(1); send(8'h77);
    idle(2);
    chk("R3 base16 held", base16, 24'h123456);
    chk("R3 pix_clk held", pix_clk, 16'h1234);
    chk("R11 stalled write staged only", rd_data, 8'h12);
    wr(8'hFF, 8'hFF); idle(1);
    chk("R4 unlocked", locked, 0);
    chk("R4 base16 committed", base16, 24'h993456);
    chk("R4 pix_clk committed", pix_clk, 16'h1277);

    // ignored control values and out-of-range address
    wr(8'hFF, 8'h55); wr(8'h40, 8'h3C); idle(1);
    chk("R12 lock unchanged", locked, 0);
    chk("R12 base8 unchanged", base8, 24'hABCDEF);

    // copy with 0xAF in the payload, then a copy back to back with a write
    send(8'hAF); send(8'h6A);
    send(8'h01); send(8'h02); send(8'h03); send(8'hAF);
    send(8'h04); send(8'h05); send(8'h06); idle(1);
    chk("R8 strobe", copy_stb, 1);
    chk("R8 src", copy_src, 24'h010203);
    chk("R8 cnt", copy_cnt, 8'hAF);
    chk("R8 dst", copy_dst, 24'h040506);
    idle(1);
    chk("R8 strobe one cycle", copy_stb, 0);
    send(8'hAF); send(8'h6A);
    for (int i = 0; i < 7; i++) send(8'(8'h30 + i));
    wr(8'h00, 8'h00); idle(1);
    chk("R8 write after copy", depth16, 1);

    // padding and restart
    send(8'hAF); send(8'hAF); send(8'h20); send(8'h00); send(8'h07); idle(1);
    chk("R10 restart write", depth16, 0);
    send(8'hAF); idle(4);
    chk("R10 lone pad no err", err, 0);
    chk("R10 lone pad no stb", copy_stb, 0);
    wr(8'h00, 8'h00); idle(1);
    chk("R10 after pad", depth16, 1);

    // unknown opcode
    send(8'hAF); send(8'h33); send(8'h20); send(8'h00); send(8'h09); idle(1);
    chk("R9 err set", err, 1);
    chk("R9 hunt drops bytes", depth16, 1);
    wr(8'h00, 8'h02); idle(1);
    chk("R9 err sticky", err, 1);
    chk("R2 write after err", depth16, 0);

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule